// File: doc/BRIEF.md
# Flash Command Decoder and Read Selector

This block sits between a host bus and a flash array with its program/erase engine. The host bus uses active-low chip enable, write enable and output enable strobes with a 16-bit data path. These strobes have already been sampled into the block's clock domain. The block reads each completed host write as a command byte and follows one- and two-write command sequences. It then decides what a host read returns: array data, identifier codes, or a snapshot of the status register.

The block does not store array data and does not run erase or program algorithms. For those it sends start, suspend and resume requests, with an operation code, address and data, to an external engine. The engine reports busy, and it reports completion with error flags that the block folds into sticky status bits. Lock configuration comes in from outside and can be read in identifier mode.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, reads return array data (`arr_rdata`) and the status value is 80h.
- R2: A host write takes effect when the enable pair stops being jointly low, whichever strobe rises first. The address and data used are those seen in the last cycle both were low. Values on the bus in the cycle of release are ignored.
- R3: Byte FFh selects array reads, 90h selects identifier reads and 70h selects status reads. Any byte with no meaning in the current state leaves the read mode unchanged.
- R4: In identifier mode, a read at address 0 returns 00B0h and a read at address 1 returns 0050h. Word offset 2 of any 32K-word block returns that block's lock bit in bit 0. Address 3 returns the permanent lock bit in bit 0. Every other address returns 0000h.
- R5: 20h then D0h pulses `eng_start` with op 0 (erase) at the confirm address. 20h followed by any other byte sets status bits 5 and 4 instead.
- R6: 40h or 10h, followed by a write of address A and data D, pulses `eng_start` with op 1, `eng_addr`=A and `eng_data`=D.
- R7: 60h then 01h, F1h or D0h pulses `eng_start` with op 2 (set block lock), op 3 (set permanent lock) or op 4 (clear block locks). Any other byte sets status bits 5 and 4.
- R8: Once a setup byte is taken, reads return status. While the engine is busy and not suspended, FFh is ignored.
- R9: B0h while the engine is busy pulses `eng_suspend`. While suspended, status bit 7 reads 1, and bit 6 (erase) or bit 2 (write) shows what was suspended. FFh, 90h and 70h still work while suspended. D0h pulses `eng_resume`, ends the suspension and returns to status reads.
- R10: Status layout: bit7 = ready (engine idle or suspended), bit6 = erase suspended, bit5 = erase/sequence error, bit4 = write/sequence error, bit3 = supply error, bit2 = write suspended, bit1 = lock error, bit0 = 0. On an `eng_done` pulse, `eng_err[3:0]` is ORed into bits 5, 4, 3 and 1. Those bits are cleared only by 50h, and 50h has no effect while suspended.
- R11: The status value returned is captured in the first cycle of a read strobe (chip and output enable both low). It does not change until the strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low, sampled |
| we_n | input | 1 | Write enable, active low, sampled |
| oe_n | input | 1 | Output enable, active low, sampled |
| addr | input | AW (19) | Word address |
| din | input | 16 | Write data / command byte in bits 7:0 |
| dout | output | 16 | Read data, 0 when no read strobe |
| arr_rdata | input | 16 | Array word at `addr` |
| blk_lock | input | 16 | Per-block lock bits |
| perm_lock | input | 1 | Permanent lock bit |
| eng_busy | input | 1 | Engine running an operation |
| eng_done | input | 1 | Engine finished, pulse |
| eng_err | input | 4 | Error flags valid with `eng_done` |
| eng_start | output | 1 | Start request, one cycle |
| eng_op | output | 3 | Operation code for the start |
| eng_addr | output | AW (19) | Operation address |
| eng_data | output | 16 | Operation data |
| eng_suspend | output | 1 | Suspend request, one cycle |
| eng_resume | output | 1 | Resume request, one cycle |

## Verification
The bench drives the bus with the release-cycle data replaced by junk, and it releases chip enable ahead of write enable. A decoder that captured at the wrong edge would execute a garbage command. It changes the engine's busy state in the middle of a held read strobe. A design whose status output tracked live values would show the new state before the strobe is released. It sends clear-status and read-array at the points where they must be ignored: during a suspension and during a busy engine. A design without those restrictions would wipe the error history or leave status mode. Bad confirm bytes after erase and lock setups must set exactly bits 5 and 4. Identifier reads at offset 1 of a non-zero block must return zero.

// File: rtl/fcui_pkg.sv
package fcui_pkg;
    typedef enum logic [1:0] {MODE_ARRAY, MODE_ID, MODE_STATUS} rmode_e;
    typedef enum logic [1:0] {PEND_NONE, PEND_ERASE, PEND_WRITE, PEND_LOCK} pend_e;
    typedef enum logic [2:0] {
        OP_ERASE     = 3'd0,
        OP_WRITE     = 3'd1,
        OP_LOCK_BLK  = 3'd2,
        OP_LOCK_PERM = 3'd3,
        OP_LOCK_CLR  = 3'd4
    } op_e;

    localparam logic [7:0] CB_ARRAY    = 8'hFF;
    localparam logic [7:0] CB_IDENT    = 8'h90;
    localparam logic [7:0] CB_STATUS   = 8'h70;
    localparam logic [7:0] CB_CLEAR    = 8'h50;
    localparam logic [7:0] CB_ERASE    = 8'h20;
    localparam logic [7:0] CB_WRITE_A  = 8'h40;
    localparam logic [7:0] CB_WRITE_B  = 8'h10;
    localparam logic [7:0] CB_LOCK     = 8'h60;
    localparam logic [7:0] CB_SUSPEND  = 8'hB0;
    localparam logic [7:0] CB_CONFIRM  = 8'hD0;
    localparam logic [7:0] CB_LOCK_BLK = 8'h01;
    localparam logic [7:0] CB_LOCK_PRM = 8'hF1;
endpackage

// File: rtl/fcui_strobe.sv
module fcui_strobe #(
    parameter int AW = 19,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_commit,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data,
    output logic          rd_active,
    output logic          rd_start
);
    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } stb_t;

    stb_t q, n;
    logic wr_now;

    assign wr_now    = !ce_n && !we_n;
    assign rd_active = !ce_n && !oe_n;

    always_comb begin
        n    = q;
        n.wr = wr_now;
        n.rd = rd_active;
        if (wr_now) begin
            n.a = addr;
            n.d = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign wr_commit = q.wr && !wr_now;
    assign cmd_addr  = q.a;
    assign cmd_data  = q.d;
    assign rd_start  = rd_active && !q.rd;
endmodule

// File: rtl/fcui_rdmux.sv
module fcui_rdmux
    import fcui_pkg::*;
#(
    parameter int          AW       = 19,
    parameter int          BW       = 15,
    parameter int          DW       = 16,
    parameter logic [15:0] MFR_CODE = 16'h00B0,
    parameter logic [15:0] DEV_CODE = 16'h0050
) (
    input  rmode_e                mode,
    input  logic                  rd_active,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         arr_rdata,
    input  logic [7:0]            snap,
    input  logic [(1<<(AW-BW))-1:0] blk_lock,
    input  logic                  perm_lock,
    output logic [DW-1:0]         dout
);
    localparam int BKW = AW - BW;

    logic [BKW-1:0] blk;
    logic [BW-1:0]  off;
    logic [DW-1:0]  id_word;

    assign blk = addr[AW-1:BW];
    assign off = addr[BW-1:0];

    always_comb begin
        id_word = '0;
        if (off == BW'(2))
            id_word[0] = blk_lock[blk];
        else if (blk == '0) begin
            if (off == BW'(0))      id_word = DW'(MFR_CODE);
            else if (off == BW'(1)) id_word = DW'(DEV_CODE);
            else if (off == BW'(3)) id_word[0] = perm_lock;
        end
    end

    always_comb begin
        dout = '0;
        if (rd_active) begin
            unique case (mode)
                MODE_ID:     dout = id_word;
                MODE_STATUS: dout = DW'(snap);
                default:     dout = arr_rdata;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import fcui_pkg::*;
#(
    parameter int AW = 19,
    parameter int BW = 15,
    parameter int DW = 16,
    localparam int NBLK = 1 << (AW - BW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            oe_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   dout,
    input  logic [DW-1:0]   arr_rdata,
    input  logic [NBLK-1:0] blk_lock,
    input  logic            perm_lock,
    input  logic            eng_busy,
    input  logic            eng_done,
    input  logic [3:0]      eng_err,
    output logic            eng_start,
    output logic [2:0]      eng_op,
    output logic [AW-1:0]   eng_addr,
    output logic [DW-1:0]   eng_data,
    output logic            eng_suspend,
    output logic            eng_resume
);
    typedef struct packed {
        rmode_e        mode;
        pend_e         pend;
        logic          susp;
        op_e           run_op;
        logic [3:0]    err;
        logic [7:0]    snap;
        logic          start;
        logic          suspend;
        logic          resume;
        op_e           op;
        logic [AW-1:0] eaddr;
        logic [DW-1:0] edata;
    } cui_t;

    cui_t q, n;

    logic          wr_commit, rd_active, rd_start;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic [7:0]    cb;
    logic [7:0]    status_now;

    fcui_strobe #(.AW(AW), .DW(DW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_commit(wr_commit), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_active(rd_active), .rd_start(rd_start)
    );

    fcui_rdmux #(.AW(AW), .BW(BW), .DW(DW)) u_rdmux (
        .mode(q.mode), .rd_active(rd_active), .addr(addr), .arr_rdata(arr_rdata),
        .snap(q.snap), .blk_lock(blk_lock), .perm_lock(perm_lock), .dout(dout)
    );

    assign cb = cmd_data[7:0];
    assign status_now = {!eng_busy || q.susp,
                         q.susp && (q.run_op == OP_ERASE),
                         q.err[3], q.err[2], q.err[1],
                         q.susp && (q.run_op == OP_WRITE),
                         q.err[0], 1'b0};

    always_comb begin
        n         = q;
        n.start   = 1'b0;
        n.suspend = 1'b0;
        n.resume  = 1'b0;
        if (eng_done) n.err = q.err | eng_err;
        if (wr_commit) begin
            if (q.pend != PEND_NONE) begin
                n.pend = PEND_NONE;
                n.mode = MODE_STATUS;
                n.eaddr = cmd_addr;
                n.edata = cmd_data;
                unique case (q.pend)
                    PEND_ERASE: begin
                        if (cb == CB_CONFIRM) begin
                            n.start = 1'b1; n.op = OP_ERASE;
                        end else n.err[3:2] = 2'b11;
                    end
                    PEND_WRITE: begin
                        n.start = 1'b1; n.op = OP_WRITE;
                    end
                    default: begin
                        n.start = 1'b1;
                        if (cb == CB_LOCK_BLK)      n.op = OP_LOCK_BLK;
                        else if (cb == CB_LOCK_PRM) n.op = OP_LOCK_PERM;
                        else if (cb == CB_CONFIRM)  n.op = OP_LOCK_CLR;
                        else begin
                            n.start = 1'b0; n.err[3:2] = 2'b11;
                        end
                    end
                endcase
                if (n.start) n.run_op = n.op;
            end else if (q.susp) begin
                case (cb)
                    CB_ARRAY:   n.mode = MODE_ARRAY;
                    CB_IDENT:   n.mode = MODE_ID;
                    CB_STATUS:  n.mode = MODE_STATUS;
                    CB_CONFIRM: begin
                        n.resume = 1'b1; n.susp = 1'b0; n.mode = MODE_STATUS;
                    end
                    default: ;
                endcase
            end else if (eng_busy) begin
                case (cb)
                    CB_STATUS:  n.mode = MODE_STATUS;
                    CB_SUSPEND: begin
                        n.suspend = 1'b1; n.susp = 1'b1; n.mode = MODE_STATUS;
                    end
                    default: ;
                endcase
            end else begin
                case (cb)
                    CB_ARRAY:   n.mode = MODE_ARRAY;
                    CB_IDENT:   n.mode = MODE_ID;
                    CB_STATUS:  n.mode = MODE_STATUS;
                    CB_CLEAR:   n.err  = '0;
                    CB_ERASE:   begin n.pend = PEND_ERASE; n.mode = MODE_STATUS; end
                    CB_WRITE_A,
                    CB_WRITE_B: begin n.pend = PEND_WRITE; n.mode = MODE_STATUS; end
                    CB_LOCK:    begin n.pend = PEND_LOCK;  n.mode = MODE_STATUS; end
                    default: ;
                endcase
            end
        end
        if (rd_start) n.snap = status_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.mode   <= MODE_ARRAY;
            q.pend   <= PEND_NONE;
            q.run_op <= OP_ERASE;
            q.op     <= OP_ERASE;
            q.snap   <= 8'h80;
        end else begin
            q <= n;
        end
    end

    assign eng_start   = q.start;
    assign eng_op      = q.op;
    assign eng_addr    = q.eaddr;
    assign eng_data    = q.edata;
    assign eng_suspend = q.suspend;
    assign eng_resume  = q.resume;

    // R5, R6, R7, R9: at most one engine request per cycle
    a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_start, eng_suspend, eng_resume}));

    // R9: a suspend request only follows a busy engine
    a_r9_suspend_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_suspend |-> $past(eng_busy));

    // R5: erase start only after a confirm byte was written
    a_r5_erase_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_op == OP_ERASE) |-> $past(wr_commit && cb == CB_CONFIRM));

    // R10: sticky bits fall only after a clear byte outside suspension
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(q.err) & ~q.err)) |-> $past(wr_commit && cb == CB_CLEAR && !q.susp));

    // R11: snapshot frozen while the read strobe stays low
    a_r11_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active)) |-> $stable(q.snap));
endmodule

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;
    localparam int AW = 19;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout, arr_rdata;
    logic [15:0] blk_lock = 16'h0002;
    logic perm_lock = 1'b0;
    logic eng_busy = 1'b0, eng_done = 1'b0;
    logic [3:0] eng_err = '0;
    logic eng_start, eng_suspend, eng_resume;
    logic [2:0] eng_op;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_data;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;
    assign arr_rdata = ~addr[15:0];

    flash_cmd_if u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .arr_rdata(arr_rdata),
        .blk_lock(blk_lock), .perm_lock(perm_lock), .eng_busy(eng_busy),
        .eng_done(eng_done), .eng_err(eng_err), .eng_start(eng_start),
        .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data),
        .eng_suspend(eng_suspend), .eng_resume(eng_resume)
    );

    typedef struct packed {
        logic        is_rd;
        logic [18:0] a;
        logic [15:0] d;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 19'h00000, 16'h0090, "R3 "},
        '{1'b1, 19'h00000, 16'h00B0, "R4 "},
        '{1'b1, 19'h00001, 16'h0050, "R4 "},
        '{1'b1, 19'h00002, 16'h0000, "R4 "},
        '{1'b1, 19'h08002, 16'h0001, "R4 "},
        '{1'b1, 19'h00003, 16'h0000, "R4 "},
        '{1'b1, 19'h08001, 16'h0000, "R4 "},
        '{1'b0, 19'h00000, 16'h0077, "R3 "},
        '{1'b1, 19'h00000, 16'h00B0, "R3 "},
        '{1'b0, 19'h00000, 16'h0070, "R3 "},
        '{1'b1, 19'h00000, 16'h0080, "R3 "},
        '{1'b0, 19'h00000, 16'h00FF, "R3 "},
        '{1'b1, 19'h00123, 16'hFEDC, "R3 "},
        '{1'b0, 19'h00000, 16'h0020, "R5 "},
        '{1'b0, 19'h00000, 16'h00FF, "R5 "},
        '{1'b1, 19'h00000, 16'h00B0, "R5 "},
        '{1'b0, 19'h00000, 16'h0050, "R10"},
        '{1'b1, 19'h00000, 16'h0080, "R10"},
        '{1'b0, 19'h00000, 16'h0060, "R7 "},
        '{1'b0, 19'h00000, 16'h0077, "R7 "},
        '{1'b1, 19'h00000, 16'h00B0, "R7 "},
        '{1'b0, 19'h00000, 16'h0050, "R10"},
        '{1'b1, 19'h00000, 16'h0080, "R10"},
        '{1'b0, 19'h00000, 16'h00FF, "R3 "},
        '{1'b1, 19'h00005, 16'hFFFA, "R3 "}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // both strobes released together; junk on the bus in the release cycle
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; addr = 19'h7FFFF; din = 16'hDEAD;
        @(negedge clk);
    endtask

    // chip enable released first, write enable later
    task automatic wr_ce_first(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk); ce_n = 1'b1; din = 16'h00FF; addr = 19'h12345;
        @(negedge clk); we_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk); chk(tag, dout, exp);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, all requirements unfinished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 dout idle", dout, 16'h0000);
        rd(19'h00042, 16'hFFBD, "R1 array after reset");
        wr(19'h0, 16'h0070);
        rd(19'h0, 16'h0080, "R1 status after reset");
        wr(19'h0, 16'h00FF);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd) rd(VEC[i].a, VEC[i].d, string'(VEC[i].tag));
            else              wr(VEC[i].a, VEC[i].d);
        end

        // R2: chip-enable-first release, later bus changes ignored
        wr_ce_first(19'h0, 16'h0090);
        rd(19'h0, 16'h00B0, "R2 ce-first capture");
        wr(19'h0, 16'h00FF);
        rd(19'h00010, 16'hFFEF, "R2 back to array");

        // R6: word write with 40h
        wr(19'h12345, 16'h0040);
        wr(19'h12345, 16'hA55A);
        chk("R6 start", eng_start, 1);
        chk("R6 op", eng_op, 1);
        chk("R6 addr", eng_addr, 19'h12345);
        chk("R6 data", eng_data, 16'hA55A);
        @(negedge clk); eng_busy = 1'b1;
        rd(19'h0, 16'h0000, "R8 status while busy");
        wr(19'h0, 16'h00FF);
        rd(19'h0, 16'h0000, "R8 array ignored while busy");
        // R9: suspend write
        wr(19'h0, 16'h00B0);
        chk("R9 suspend pulse", eng_suspend, 1);
        rd(19'h0, 16'h0084, "R9 write suspended status");
        wr(19'h0, 16'h00D0);
        chk("R9 resume pulse", eng_resume, 1);
        rd(19'h0, 16'h0000, "R9 after resume");
        // R10: error from engine
        @(negedge clk); eng_done = 1'b1; eng_err = 4'b0100; eng_busy = 1'b0;
        @(negedge clk); eng_done = 1'b0; eng_err = '0;
        rd(19'h0, 16'h0090, "R10 sticky write error");

        // R5: erase
        wr(19'h10005, 16'h0020);
        wr(19'h10005, 16'h00D0);
        chk("R5 start", eng_start, 1);
        chk("R5 op", eng_op, 0);
        chk("R5 addr", eng_addr, 19'h10005);
        @(negedge clk); eng_busy = 1'b1;
        rd(19'h0, 16'h0010, "R8 status during erase");
        // R11: snapshot held while strobe low
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = 19'h0;
        @(negedge clk); chk("R11 first value", dout, 16'h0010);
        eng_busy = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 held value", dout, 16'h0010);
        ce_n = 1'b1; oe_n = 1'b1;
        rd(19'h0, 16'h0090, "R11 fresh value");
        @(negedge clk); eng_busy = 1'b1;
        wr(19'h0, 16'h00B0);
        rd(19'h0, 16'h00D0, "R9 erase suspended status");
        wr(19'h0, 16'h0050);
        rd(19'h0, 16'h00D0, "R10 clear ignored in suspend");
        wr(19'h0, 16'h00FF);
        rd(19'h00007, 16'hFFF8, "R9 array read in suspend");
        wr(19'h0, 16'h00D0);
        rd(19'h0, 16'h0010, "R9 resumed erase");
        @(negedge clk); eng_busy = 1'b0;
        wr(19'h0, 16'h0050);
        rd(19'h0, 16'h0080, "R10 cleared");

        // R7: lock operations
        wr(19'h0, 16'h0060); wr(19'h18000, 16'h0001);
        chk("R7 set block op", {eng_start, eng_op}, {1'b1, 3'd2});
        chk("R7 set block addr", eng_addr, 19'h18000);
        wr(19'h0, 16'h0060); wr(19'h0, 16'h00F1);
        chk("R7 permanent op", {eng_start, eng_op}, {1'b1, 3'd3});
        wr(19'h0, 16'h0060); wr(19'h0, 16'h00D0);
        chk("R7 clear op", {eng_start, eng_op}, {1'b1, 3'd4});
        // R6: 10h alias
        wr(19'h0, 16'h0010); wr(19'h00003, 16'h1234);
        chk("R6 alias op", {eng_start, eng_op}, {1'b1, 3'd1});
        chk("R6 alias data", eng_data, 16'h1234);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule